// File: doc/BRIEF.md
# Single-Precision Rounding Packer

This block takes an operand held in unpacked form and turns it into a 32-bit IEEE-754 single-precision word. The operand arrives as a class code, a sign, an unbiased signed exponent, a normalized mantissa and a sticky bit. The mantissa holds the implied one, the 23 fraction bits and two extra bits below them, a guard and a round bit. A 2-bit mode input selects the rounding direction. An underflow-trap-enable input affects only the underflow flag.

The block handles non-numbers, infinities and zeros directly. For finite values it selects the normal or the subnormal path and shifts subnormals down, folding the lost bits into the sticky bit. It then rounds and handles two carries: a carry into the next binade, and a carry from the subnormal range into the smallest normal. Results past the top of the exponent range saturate to infinity or to the largest finite value, depending on the mode and the sign.

Alongside the packed word it reports five flags: inexact, fraction-inexact, fraction-rounded, overflow and underflow. Word and flags are registered. They appear one clock after the cycle in which `in_valid` is high.

Top module: `sp_round_pack`

## Requirements
- R1: Class code 0 (zero) packs as the sign in bit 31 with every other bit clear, and raises no flag.
- R2: Class code 2 (infinity) packs as the sign, an exponent field (bits 30:23) of all ones and a zero fraction, and raises no flag.
- R3: Class code 3 (NaN) packs as the sign, an all-ones exponent field, and a fraction equal to mantissa bits 24:2 with fraction bit 22 (the quiet bit) forced to one. It raises no flag.
- R4: For class code 1 (number) with biased exponent (input exponent + 127) between 1 and 254, the exponent field is the biased exponent. The fraction is mantissa bits 24:2, rounded at bit 2 according to the mode. Mode 0 is round to nearest: it increments when bit 1 (guard) is set and any of bit 0 (round), sticky or bit 2 is set, so exact ties go to even. Mode 1 is toward zero and never increments. Mode 2 is toward plus infinity and increments inexact positives. Mode 3 is toward minus infinity and increments inexact negatives.
- R5: The inexact and fraction-inexact flags are set exactly when any bit discarded by rounding (guard, round, sticky, or bits shifted out on the subnormal path) is nonzero. The fraction-rounded flag is set exactly when the kept value was incremented.
- R6: If rounding a normal carries the significand to 2.0, the exponent field is one higher and the fraction field is zero.
- R7: If the biased exponent is 0 or less, the significand including the implied one shifts right by one plus the negated biased exponent. Bits shifted out join the sticky bit. The exponent field is 0 and the fraction is the rounded shifted value.
- R8: A subnormal that rounds up into the implied-one position packs as the sign with exponent field 1 and a zero fraction, and does not raise underflow.
- R9: Underflow is raised exactly when the result stays subnormal and is either inexact or the underflow-trap-enable input is high.
- R10: If the exponent after rounding is 255 or more, the result is infinity in mode 0, the largest finite magnitude (0x7F7FFFFF with the sign) in mode 1, infinity in mode 2 only for positives, and infinity in mode 3 only for negatives. In the remaining cases it is the largest finite magnitude.
- R11: The overflow flag is raised exactly when an overflowing result is packed as infinity.
- R12: Reset clears `out_valid`, the word and all flags. `out_valid` follows `in_valid` one clock later. The word and flags change only on a clock where `in_valid` was high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operand present this cycle |
| in_class | input | 2 | 0 zero, 1 number, 2 infinity, 3 NaN |
| in_sign | input | 1 | Operand sign |
| in_exp | input | 10 | Unbiased exponent, two's complement |
| in_mant | input | 26 | Implied one (bit 25), fraction (24:2), guard (1), round (0) |
| in_sticky | input | 1 | OR of all bits below the round bit |
| in_mode | input | 2 | 0 nearest-even, 1 toward zero, 2 toward +inf, 3 toward -inf |
| in_uf_trap | input | 1 | Underflow trap enabled |
| out_valid | output | 1 | Registered result valid |
| out_word | output | 32 | Packed single-precision word |
| out_inexact | output | 1 | Result inexact |
| out_frac_inexact | output | 1 | Fraction inexact |
| out_frac_rounded | output | 1 | Fraction was incremented |
| out_overflow | output | 1 | Overflowed to infinity |
| out_underflow | output | 1 | Underflow signalled |

## Verification
The main sweep covers every rounding mode and both signs. Exponents cluster around the subnormal floor, around the normal/subnormal boundary and just below the top of the range. Fraction patterns include zero, all ones and alternating bits, and every guard/round combination is tried with sticky clear and set. The all-ones fractions tell a plain increment apart from the binade carry and the carry into the smallest normal. The guard-only patterns with sticky clear separate a nearest-even tie from a round-up, and the sign flips show whether the directed modes pick the right direction at overflow. Separate passes over the three special classes with a quiet bit left clear, and an idle-cycle probe, show that these paths ignore the rounding inputs and that the outputs hold while no operand is present.

// File: rtl/sp_pack_pkg.sv
package sp_pack_pkg;

    typedef enum logic [1:0] {
        CLS_ZERO = 2'd0,
        CLS_NUM  = 2'd1,
        CLS_INF  = 2'd2,
        CLS_NAN  = 2'd3
    } opclass_e;

    typedef enum logic [1:0] {
        RND_NEAREST = 2'd0,
        RND_ZERO    = 2'd1,
        RND_POS     = 2'd2,
        RND_NEG     = 2'd3
    } rmode_e;

    typedef struct packed {
        logic inexact;
        logic frac_inexact;
        logic frac_rounded;
        logic overflow;
        logic underflow;
    } pack_flags_t;

    // Whether an overflowing result saturates to infinity.
    function automatic logic overflow_to_inf(rmode_e mode, logic sign);
        case (mode)
            RND_NEAREST: return 1'b1;
            RND_ZERO:    return 1'b0;
            RND_POS:     return !sign;
            default:     return sign;
        endcase
    endfunction

    // Increment decision from kept LSB, guard bit, and merged round/sticky.
    function automatic logic round_up(rmode_e mode, logic sign, logic lsb,
                                      logic guard, logic rest);
        case (mode)
            RND_NEAREST: return guard && (rest || lsb);
            RND_ZERO:    return 1'b0;
            RND_POS:     return (guard || rest) && !sign;
            default:     return (guard || rest) && sign;
        endcase
    endfunction

endpackage

// File: rtl/sp_pack_align.sv
module sp_pack_align #(
    parameter int MANT_W = 26,
    parameter int BEXP_W = 12
) (
    input  logic signed [BEXP_W-1:0] biased,
    input  logic [MANT_W-1:0]        mant,
    input  logic                     sticky,
    output logic [MANT_W-1:0]        mant_al,
    output logic                     sticky_al,
    output logic                     subnormal
);
    localparam int SH_W = $clog2(MANT_W + 1);

    logic signed [BEXP_W:0] deficit;
    logic [SH_W-1:0]        sh;
    logic [MANT_W-1:0]      lost_mask;

    always_comb begin
        subnormal = (biased <= 0);
        deficit   = $signed((BEXP_W+1)'(1)) - $signed({biased[BEXP_W-1], biased});
        if (!subnormal)
            sh = '0;
        else if (deficit >= $signed((BEXP_W+1)'(MANT_W)))
            sh = SH_W'(MANT_W);
        else
            sh = deficit[SH_W-1:0];
        lost_mask = ~({MANT_W{1'b1}} << sh);
        mant_al   = mant >> sh;
        sticky_al = sticky | (|(mant & lost_mask));
    end
endmodule

// File: rtl/sp_pack_round.sv
module sp_pack_round
    import sp_pack_pkg::*;
#(
    parameter int MANT_W = 26,
    parameter int NG     = 2
) (
    input  logic [MANT_W-1:0]    mant_al,
    input  logic                 sticky,
    input  logic [1:0]           mode,
    input  logic                 sign,
    output logic [MANT_W-NG:0]   sum,
    output logic                 inexact,
    output logic                 inc
);
    localparam int KEEP_W = MANT_W - NG;

    logic [KEEP_W-1:0] keep;
    logic              guard;
    logic              rest;

    always_comb begin
        keep    = mant_al[MANT_W-1:NG];
        guard   = mant_al[NG-1];
        rest    = (|mant_al[NG-2:0]) | sticky;
        inexact = guard | rest;
        inc     = round_up(rmode_e'(mode), sign, keep[0], guard, rest);
        sum     = {1'b0, keep} + (KEEP_W+1)'(inc);
    end
endmodule

// File: rtl/sp_round_pack.sv
module sp_round_pack
    import sp_pack_pkg::*;
#(
    parameter int FRAC_W = 23,
    parameter int EXP_W  = 8,
    parameter int EIN_W  = 10,
    parameter int NG     = 2
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     in_valid,
    input  logic [1:0]               in_class,
    input  logic                     in_sign,
    input  logic signed [EIN_W-1:0]  in_exp,
    input  logic [FRAC_W+NG:0]       in_mant,
    input  logic                     in_sticky,
    input  logic [1:0]               in_mode,
    input  logic                     in_uf_trap,
    output logic                     out_valid,
    output logic [EXP_W+FRAC_W:0]    out_word,
    output logic                     out_inexact,
    output logic                     out_frac_inexact,
    output logic                     out_frac_rounded,
    output logic                     out_overflow,
    output logic                     out_underflow
);
    localparam int MANT_W  = FRAC_W + 1 + NG;
    localparam int WORD_W  = 1 + EXP_W + FRAC_W;
    localparam int BEXP_W  = EIN_W + 2;
    localparam int BIAS    = (1 << (EXP_W - 1)) - 1;
    localparam int EXP_MAX = (1 << EXP_W) - 1;

    logic signed [BEXP_W-1:0] biased;
    logic signed [BEXP_W-1:0] exp_fin;
    logic [MANT_W-1:0]        mant_al;
    logic                     sticky_al;
    logic                     subnormal;
    logic [MANT_W-NG:0]       sum;
    logic                     inexact;
    logic                     inc;
    logic                     carry;

    logic [WORD_W-1:0]        word_d;
    pack_flags_t              flags_d;
    pack_flags_t              flags_q;

    assign biased = $signed({{2{in_exp[EIN_W-1]}}, in_exp}) + $signed(BEXP_W'(BIAS));

    sp_pack_align #(.MANT_W(MANT_W), .BEXP_W(BEXP_W)) u_align (
        .biased   (biased),
        .mant     (in_mant),
        .sticky   (in_sticky),
        .mant_al  (mant_al),
        .sticky_al(sticky_al),
        .subnormal(subnormal)
    );

    sp_pack_round #(.MANT_W(MANT_W), .NG(NG)) u_round (
        .mant_al(mant_al),
        .sticky (sticky_al),
        .mode   (in_mode),
        .sign   (in_sign),
        .sum    (sum),
        .inexact(inexact),
        .inc    (inc)
    );

    // Assembly of the packed word per class and path.
    always_comb begin
        word_d  = '0;
        flags_d = '0;
        carry   = sum[FRAC_W+1];
        exp_fin = biased + BEXP_W'(carry);
        case (opclass_e'(in_class))
            CLS_ZERO: word_d = {in_sign, {(WORD_W-1){1'b0}}};
            CLS_INF:  word_d = {in_sign, {EXP_W{1'b1}}, {FRAC_W{1'b0}}};
            CLS_NAN:  word_d = {in_sign, {EXP_W{1'b1}},
                                in_mant[MANT_W-2:NG] | (FRAC_W'(1) << (FRAC_W-1))};
            default: begin
                flags_d.inexact      = inexact;
                flags_d.frac_inexact = inexact;
                flags_d.frac_rounded = inc;
                if (subnormal) begin
                    if (sum[FRAC_W]) begin
                        word_d = {in_sign, EXP_W'(1), {FRAC_W{1'b0}}};
                    end else begin
                        word_d = {in_sign, {EXP_W{1'b0}}, sum[FRAC_W-1:0]};
                        flags_d.underflow = inexact | in_uf_trap;
                    end
                end else if (exp_fin >= $signed(BEXP_W'(EXP_MAX))) begin
                    if (overflow_to_inf(rmode_e'(in_mode), in_sign)) begin
                        word_d = {in_sign, {EXP_W{1'b1}}, {FRAC_W{1'b0}}};
                        flags_d.overflow = 1'b1;
                    end else begin
                        word_d = {in_sign, {(EXP_W-1){1'b1}}, 1'b0, {FRAC_W{1'b1}}};
                    end
                end else begin
                    word_d = {in_sign, exp_fin[EXP_W-1:0], sum[FRAC_W-1:0]};
                end
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            out_word  <= '0;
            flags_q   <= '0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) begin
                out_word <= word_d;
                flags_q  <= flags_d;
            end
        end
    end

    assign out_inexact      = flags_q.inexact;
    assign out_frac_inexact = flags_q.frac_inexact;
    assign out_frac_rounded = flags_q.frac_rounded;
    assign out_overflow     = flags_q.overflow;
    assign out_underflow    = flags_q.underflow;

    // R12: valid tracks the input one clock later
    a_r12_valid_follows: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid);
    // R12: no operand, no change of the packed word
    a_r12_hold_word: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> $stable(out_word) && !out_valid);
    // R11: overflow flag only accompanies an infinity
    a_r11_ovf_is_inf: assert property (@(posedge clk) disable iff (rst)
        out_overflow |-> out_word[WORD_W-2:0] == {{EXP_W{1'b1}}, {FRAC_W{1'b0}}});
    // R9: underflow only with a zero exponent field
    a_r9_uf_subnormal: assert property (@(posedge clk) disable iff (rst)
        out_underflow |-> out_word[WORD_W-2:FRAC_W] == '0);
    // R5: an increment implies inexact
    a_r5_round_needs_inexact: assert property (@(posedge clk) disable iff (rst)
        out_frac_rounded |-> out_inexact && out_frac_inexact);
    // R4: toward-zero never increments
    a_r4_rz_no_inc: assert property (@(posedge clk) disable iff (rst)
        in_valid && in_mode == 2'd1 |=> !out_frac_rounded);
endmodule

// File: tb/sp_round_pack_bench.sv
module sp_round_pack_bench;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 150000;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic [1:0]  in_class = 2'd0;
    logic        in_sign = 1'b0;
    logic signed [9:0] in_exp = '0;
    logic [25:0] in_mant = '0;
    logic        in_sticky = 1'b0;
    logic [1:0]  in_mode = 2'd0;
    logic        in_uf_trap = 1'b0;
    logic        out_valid;
    logic [31:0] out_word;
    logic        out_inexact, out_frac_inexact, out_frac_rounded;
    logic        out_overflow, out_underflow;

    int total = 0;
    int fails = 0;
    bit done  = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    sp_round_pack u_sp_round_pack (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_class(in_class),
        .in_sign(in_sign), .in_exp(in_exp), .in_mant(in_mant),
        .in_sticky(in_sticky), .in_mode(in_mode), .in_uf_trap(in_uf_trap),
        .out_valid(out_valid), .out_word(out_word), .out_inexact(out_inexact),
        .out_frac_inexact(out_frac_inexact), .out_frac_rounded(out_frac_rounded),
        .out_overflow(out_overflow), .out_underflow(out_underflow)
    );

    task automatic check(input bit ok, input string tag, input string what,
                         input longint act, input longint exp);
        total++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    // Arithmetic reference: quotient/remainder view of the rounding step.
    task automatic ref_model(input bit s, input int e, input longint m,
                             input bit st, input int mode, input bit trap,
                             output longint w, output bit inx, output bit fr,
                             output bit ov, output bit uf, output string tag);
        int be = e + 127;
        bit sub = (be <= 0);
        int k = sub ? (3 - be) : 2;
        longint q, rem, twor, full, q2;
        bit above, tie, nz, up, inf;
        if (k > 40) k = 40;
        q    = m >> k;
        rem  = m - (q << k);
        twor = rem * 2 + longint'(st);
        full = longint'(1) << k;
        above = twor > full;
        tie   = twor == full;
        nz    = (rem != 0) || st;
        case (mode)
            0: up = above || (tie && q[0]);
            1: up = 0;
            2: up = nz && !s;
            default: up = nz && s;
        endcase
        q2 = q + longint'(up);
        inx = nz; fr = up; ov = 0; uf = 0;
        if (sub) begin
            if (q2 == (longint'(1) << 23)) begin
                w = (longint'(s) << 31) | 64'h800000; tag = "R8";
            end else begin
                w = (longint'(s) << 31) | q2; uf = nz || trap; tag = "R7";
            end
        end else begin
            int ee = be;
            longint f = q2 & 64'h7FFFFF;
            tag = "R4";
            if (q2 == (longint'(1) << 24)) begin ee = be + 1; f = 0; tag = "R6"; end
            if (ee >= 255) begin
                inf = (mode == 0) || (mode == 2 && !s) || (mode == 3 && s);
                ov = inf; tag = "R10";
                w = (longint'(s) << 31) | (inf ? 64'h7F800000 : 64'h7F7FFFFF);
            end else begin
                w = (longint'(s) << 31) | (longint'(ee) << 23) | f;
            end
        end
    endtask

    task automatic apply(input int cls, input bit s, input int e, input longint m,
                         input bit st, input int mode, input bit trap);
        @(negedge clk);
        in_valid = 1'b1; in_class = cls[1:0]; in_sign = s; in_exp = e[9:0];
        in_mant = m[25:0]; in_sticky = st; in_mode = mode[1:0]; in_uf_trap = trap;
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    task automatic run_num(input bit s, input int e, input longint m,
                           input bit st, input int mode, input bit trap);
        longint w; bit inx, fr, ov, uf; string tag;
        ref_model(s, e, m, st, mode, trap, w, inx, fr, ov, uf, tag);
        apply(1, s, e, m, st, mode, trap);
        check(out_word == w[31:0], tag, "word", longint'(out_word), w);
        check(out_inexact == inx && out_frac_inexact == inx, "R5", "inexact",
              longint'({out_inexact, out_frac_inexact}), longint'({inx, inx}));
        check(out_frac_rounded == fr, "R5", "rounded", longint'(out_frac_rounded), longint'(fr));
        check(out_underflow == uf, "R9", "underflow", longint'(out_underflow), longint'(uf));
        check(out_overflow == ov, "R11", "overflow", longint'(out_overflow), longint'(ov));
        check(out_valid == 1'b1, "R12", "valid", longint'(out_valid), 1);
    endtask

    task automatic run_special(input int cls, input bit s, input longint m, input int mode,
                               input string tag);
        longint w;
        if (cls == 0)      w = longint'(s) << 31;
        else if (cls == 2) w = (longint'(s) << 31) | 64'h7F800000;
        else               w = (longint'(s) << 31) | 64'h7F800000 | ((m >> 2) & 64'h7FFFFF) | 64'h400000;
        apply(cls, s, 5, m, 1'b1, mode, 1'b1);
        check(out_word == w[31:0], tag, "special word", longint'(out_word), w);
        check({out_inexact, out_frac_inexact, out_frac_rounded, out_overflow, out_underflow} == 5'b0,
              tag, "special flags",
              longint'({out_inexact, out_frac_inexact, out_frac_rounded, out_overflow, out_underflow}), 0);
    endtask

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        if (!done) begin
            fails++; total++;
            $display("FAIL R12 watchdog: actual %0d expected %0d", WATCHDOG, 0);
            $display("%0d/%0d checks passed", total - fails, total);
            $finish;
        end
    end

    initial begin
        int exps[$];
        longint fracs[8] = '{64'h0, 64'h1, 64'h2, 64'h7FFFFF, 64'h7FFFFE,
                             64'h400000, 64'h2AAAAA, 64'h555555};
        int idx = 0;
        logic [31:0] held;

        repeat (3) @(negedge clk);
        // R12: reset state
        check(out_valid == 0 && out_word == 0, "R12", "reset",
              longint'({out_valid, out_word}), 0);
        check({out_inexact, out_frac_inexact, out_frac_rounded, out_overflow, out_underflow} == 0,
              "R12", "reset flags",
              longint'({out_inexact, out_frac_inexact, out_frac_rounded, out_overflow, out_underflow}), 0);
        rst = 1'b0;

        // R1, R2, R3: special classes ignore rounding inputs
        for (int md = 0; md < 4; md++) begin
            for (int s = 0; s < 2; s++) begin
                run_special(0, s[0], 64'h3FFFFFF, md, "R1");
                run_special(2, s[0], 64'h3FFFFFF, md, "R2");
                run_special(3, s[0], 64'h2000004, md, "R3");
                run_special(3, s[0], 64'h3FFFFFF, md, "R3");
                run_special(3, s[0], 64'h2AAAAAB, md, "R3");
            end
        end

        exps.push_back(-300);
        for (int e = -152; e <= -124; e++) exps.push_back(e);
        for (int e = -3; e <= 3; e++) exps.push_back(e);
        for (int e = 124; e <= 130; e++) exps.push_back(e);
        exps.push_back(300);

        // R4..R11: sweep of modes, signs, exponents, fractions, guard/round, sticky
        for (int md = 0; md < 4; md++)
            for (int s = 0; s < 2; s++)
                foreach (exps[i])
                    for (int f = 0; f < 8; f++)
                        for (int gr = 0; gr < 4; gr++)
                            for (int st = 0; st < 2; st++) begin
                                longint m = (longint'(1) << 25) | (fracs[f] << 2) | longint'(gr);
                                idx++;
                                run_num(s[0], exps[i], m, st[0], md, idx[0]);
                            end

        // R9: exact subnormal with trap enabled vs disabled
        run_num(1'b0, -130, 64'h2000000, 1'b0, 0, 1'b1);
        run_num(1'b0, -130, 64'h2000000, 1'b0, 0, 1'b0);

        // R12: hold while idle
        run_num(1'b1, 10, 64'h2ABCDE5, 1'b1, 2, 1'b0);
        held = out_word;
        @(negedge clk);
        in_sign = 1'b0; in_exp = 10'sd3; in_mant = 26'h3FFFFFF; in_class = 2'd2;
        @(negedge clk);
        check(out_word == held, "R12", "hold word", longint'(out_word), longint'(held));
        check(out_valid == 1'b0, "R12", "idle valid", longint'(out_valid), 0);

        done = 1;
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end
endmodule